// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the bus-side command interpreter of a byte-wide flash device, written as a synchronous model. It watches single-cycle write strobes, each with an address and a data byte. It recognises the command sequences that start with the two unlock writes. Each recognised command becomes a one-clock request to the embedded-operation engine. The commands are byte program, whole-array erase, single-sector erase and boot-block lockout. The address and data of the final write travel with each request.

The block also tracks an identification mode. While that mode is active, reads of the three lowest addresses are answered by the decoder rather than by the array: a maker code, a device code and the boot-block lockout state. The array storage and the timing of embedded operations are outside this block. The array controller reports that an operation is in progress through a busy input. While busy is high, the decoder ignores every write.

Top module: `flash_cmd_seq`

## Requirements
- R1: Unlock and command addresses are compared on address bits 14..0 only. Bits 17..15 of a write have no effect on matching. The unlock pair is data 0xAA at 0x5555 followed by data 0x55 at 0x2AAA.
- R2: Unlock followed by 0xA0 at 0x5555 arms byte program. The next accepted write, whatever its address and data (0xF0 included), raises `progReq` and carries that write's address and data.
- R3: Unlock, 0x80 at 0x5555, the unlock pair again, then 0x10 at 0x5555 raises `chipEraseReq`.
- R4: The same six-write prefix followed by 0x30 at any address raises `sectEraseReq`. `reqAddr` then holds the full 18-bit address of that write. Any other sixth write raises no request.
- R5: The six-write prefix followed by 0x40 at 0x5555 raises `lockReq` and sets the lockout state. Only reset clears that state.
- R6: Unlock followed by 0x90 at 0x5555 sets `idMode`.
- R7: A read is answered in the cycle after `rdEn`. In identification mode, address 0 gives `rdHit`=1 with 0xDA, address 1 gives 0x0B, and address 2 gives the lockout state in bit 0 (1 = locked) with the other bits 0. Every other address, and every read outside identification mode, gives `rdHit`=0 and `rdData`=0.
- R8: Identification mode is cleared by a single write of 0xF0 at any address, or by the unlock pair followed by 0xF0 at 0x5555. Under the three-write form, `idMode` stays set until the third write.
- R9: A write that is not the expected next step returns the sequence to idle and starts nothing. The write after it is decoded from idle.
- R10: A write while `busy` is high is ignored. It neither advances nor resets the sequence, and it raises no request.
- R11: Each request is a one-clock pulse in the cycle after the final write. At most one request is high at a time. `reqAddr` and `reqData` change only with a request.
- R12: After reset all requests, `idMode`, the lockout state, `rdHit`, `rdData`, `reqAddr` and `reqData` are zero, and the sequence is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per bus write |
| wrAddr | input | 18 | Write address |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 18 | Read address |
| busy | input | 1 | Embedded operation in progress; writes ignored |
| progReq | output | 1 | Byte program request pulse |
| chipEraseReq | output | 1 | Whole-array erase request pulse |
| sectEraseReq | output | 1 | Sector erase request pulse |
| lockReq | output | 1 | Boot-block lockout request pulse |
| reqAddr | output | 18 | Address of the write that completed the last request |
| reqData | output | 8 | Data of the write that completed the last request |
| idMode | output | 1 | Identification mode active |
| rdHit | output | 1 | Read data below comes from the decoder |
| rdData | output | 8 | Identification read data |

## Verification
On every cycle, the assertions check these properties:
- Requests are one-hot and one cycle wide.
- The latched address and data stay stable between requests.
- A busy write leaves the sequence state untouched.
- The program step always returns the sequence to idle.
- Identification mode is entered only by a 0x90 write.
- A read hit is always preceded by a read strobe taken in identification mode.

Only the bench's scenarios can show that each full command sequence produces the right request with the right address. They also show the following:
- The upper address bits are ignored when matching.
- A broken sequence does not resume.
- A busy write does not disturb the sequence armed around it.
- Both exit forms leave identification mode at the right write.
- The lockout state read back at address 2 follows the lockout command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_PROG  = 3'd3,
    ST_ERS3  = 3'd4,
    ST_ERS4  = 3'd5,
    ST_ERS5  = 3'd6
  } seqState_t;

  typedef struct packed {
    logic prog;
    logic chipErase;
    logic sectErase;
    logic lock;
    logic idEnter;
    logic idExit;
  } cmdStrobe_t;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASESET = 8'h80;
  localparam logic [7:0] OP_IDENTER  = 8'h90;
  localparam logic [7:0] OP_EXIT     = 8'hF0;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_LOCK     = 8'h40;

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W   = 15,
  parameter int DATA_W  = 8,
  parameter logic [CMP_W-1:0] ADDR_KEY1 = 15'h5555,
  parameter logic [CMP_W-1:0] ADDR_KEY2 = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CMP_W-1:0]  wrAddrLo,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  output cmdStrobe_t        strobe
);

  seqState_t state, stateNext;
  logic accept, atKey1, atKey2, isExit;

  assign accept = wrEn && !busy;
  assign atKey1 = (wrAddrLo == ADDR_KEY1);
  assign atKey2 = (wrAddrLo == ADDR_KEY2);
  assign isExit = (wrData == OP_EXIT);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (accept) begin
      stateNext = ST_IDLE;
      // Single-write exit: any 0xF0 outside the program-data step
      strobe.idExit = isExit && (state != ST_PROG);
      unique case (state)
        ST_IDLE: if (atKey1 && wrData == KEY_FIRST)  stateNext = ST_UNL1;
        ST_UNL1: if (atKey2 && wrData == KEY_SECOND) stateNext = ST_UNL2;
        ST_UNL2: if (atKey1) begin
          if (wrData == OP_PROGRAM)       stateNext = ST_PROG;
          else if (wrData == OP_ERASESET) stateNext = ST_ERS3;
          else if (wrData == OP_IDENTER)  strobe.idEnter = 1'b1;
        end
        ST_PROG: strobe.prog = 1'b1;
        ST_ERS3: if (atKey1 && wrData == KEY_FIRST)  stateNext = ST_ERS4;
        ST_ERS4: if (atKey2 && wrData == KEY_SECOND) stateNext = ST_ERS5;
        ST_ERS5: begin
          if (wrData == OP_SECTOR)                strobe.sectErase = 1'b1;
          else if (atKey1 && wrData == OP_CHIP)   strobe.chipErase = 1'b1;
          else if (atKey1 && wrData == OP_LOCK)   strobe.lock      = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R10: a write taken while busy leaves the sequence where it was
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> $stable(state));

  // R2: the program data step always closes the sequence
  p_prog_closes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG && wrEn && !busy) |=> state == ST_IDLE);

  // R9: a wrong second unlock write drops back to idle
  p_mismatch_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNL1 && wrEn && !busy && wrData != KEY_SECOND) |=> state == ST_IDLE);

endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MAKER_CODE  = 8'hDA,
  parameter logic [DATA_W-1:0] DEVICE_CODE = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              progReq,
  output logic              chipEraseReq,
  output logic              sectEraseReq,
  output logic              lockReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              idMode,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData
);

  localparam int ID_SLOTS = 3;

  logic anyStrobe, anyReq, locked;
  logic [DATA_W-1:0] idTable [ID_SLOTS];
  logic [ID_SLOTS-1:0] slotSel;

  assign anyStrobe = strobe.prog | strobe.chipErase | strobe.sectErase | strobe.lock;
  assign anyReq    = progReq | chipEraseReq | sectEraseReq | lockReq;

  assign idTable[0] = MAKER_CODE;
  assign idTable[1] = DEVICE_CODE;
  assign idTable[2] = {{(DATA_W-1){1'b0}}, locked};

  for (genvar s = 0; s < ID_SLOTS; s++) begin : g_slot
    assign slotSel[s] = (rdAddr == ADDR_W'(s));
  end

  logic [DATA_W-1:0] idWord;
  always_comb begin
    idWord = '0;
    for (int s = 0; s < ID_SLOTS; s++)
      if (slotSel[s]) idWord = idTable[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progReq      <= 1'b0;
      chipEraseReq <= 1'b0;
      sectEraseReq <= 1'b0;
      lockReq      <= 1'b0;
      reqAddr      <= '0;
      reqData      <= '0;
      idMode       <= 1'b0;
      locked       <= 1'b0;
      rdHit        <= 1'b0;
      rdData       <= '0;
    end else begin
      progReq      <= strobe.prog;
      chipEraseReq <= strobe.chipErase;
      sectEraseReq <= strobe.sectErase;
      lockReq      <= strobe.lock;
      if (anyStrobe) begin
        reqAddr <= wrAddr;
        reqData <= wrData;
      end
      if (strobe.lock)         locked <= 1'b1;
      if (strobe.idEnter)      idMode <= 1'b1;
      else if (strobe.idExit)  idMode <= 1'b0;
      rdHit  <= rdEn && idMode && (|slotSel);
      rdData <= (rdEn && idMode) ? idWord : '0;
    end
  end

  // R11: never two requests at once
  p_req_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progReq, chipEraseReq, sectEraseReq, lockReq}));

  // R11: a request lasts exactly one clock
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> !anyReq);

  // R11: latched address and data only move with a request
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |-> ($stable(reqAddr) && $stable(reqData)));

  // R6: identification mode only starts from a 0x90 write
  p_id_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> ($past(wrEn) && $past(wrData) == OP_IDENTER));

  // R7: a hit needs a read strobe while in identification mode
  p_rd_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> ($past(rdEn) && $past(idMode)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              busy,
  output logic              progReq,
  output logic              chipEraseReq,
  output logic              sectEraseReq,
  output logic              lockReq,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              idMode,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData
);

  cmdStrobe_t strobe;

  fcs_ctrl #(.CMP_W(CMP_W), .DATA_W(DATA_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddrLo (wrAddr[CMP_W-1:0]),
    .wrData   (wrData),
    .busy     (busy),
    .strobe   (strobe)
  );

  fcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdEn         (rdEn),
    .rdAddr       (rdAddr),
    .progReq      (progReq),
    .chipEraseReq (chipEraseReq),
    .sectEraseReq (sectEraseReq),
    .lockReq      (lockReq),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .idMode       (idMode),
    .rdHit        (rdHit),
    .rdData       (rdData)
  );

endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [17:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [17:0] rdAddr = '0;
  logic        busy = 1'b0;
  logic        progReq, chipEraseReq, sectEraseReq, lockReq, idMode, rdHit;
  logic [17:0] reqAddr;
  logic [7:0]  reqData, rdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [17:0] lastAddr = '0;
  logic [7:0]  lastData = '0;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .busy(busy),
    .progReq(progReq), .chipEraseReq(chipEraseReq), .sectEraseReq(sectEraseReq),
    .lockReq(lockReq), .reqAddr(reqAddr), .reqData(reqData),
    .idMode(idMode), .rdHit(rdHit), .rdData(rdData)
  );

  always #4 clk = ~clk;

  // vector: addr, data, busy, expected request code, expected idMode
  // request code: 0 none, 1 program, 2 chip erase, 3 sector erase, 4 lockout
  function automatic logic [30:0] mk(input logic [17:0] a, input logic [7:0] d,
                                     input logic b, input logic [2:0] r, input logic i);
    return {a, d, b, r, i};
  endfunction

  localparam int NV = 47;
  localparam logic [30:0] VEC [NV] = '{
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R2
    mk(18'h05555, 8'hA0, 0, 0, 0), mk(18'h01234, 8'hF0, 0, 1, 0),
    mk(18'h15555, 8'hAA, 0, 0, 0), mk(18'h22AAA, 8'h55, 0, 0, 0),      // R1, R3
    mk(18'h35555, 8'h80, 0, 0, 0), mk(18'h05555, 8'hAA, 0, 0, 0),
    mk(18'h02AAA, 8'h55, 0, 0, 0), mk(18'h05555, 8'h10, 0, 2, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R4
    mk(18'h05555, 8'h80, 0, 0, 0), mk(18'h05555, 8'hAA, 0, 0, 0),
    mk(18'h02AAA, 8'h55, 0, 0, 0), mk(18'h3A123, 8'h30, 0, 3, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R5
    mk(18'h05555, 8'h80, 0, 0, 0), mk(18'h05555, 8'hAA, 0, 0, 0),
    mk(18'h02AAA, 8'h55, 0, 0, 0), mk(18'h05555, 8'h40, 0, 4, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h01234, 8'h55, 0, 0, 0),      // R9
    mk(18'h05555, 8'hA0, 0, 0, 0), mk(18'h00000, 8'h12, 0, 0, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R10
    mk(18'h05555, 8'hA0, 0, 0, 0), mk(18'h00100, 8'h77, 1, 0, 0),
    mk(18'h00200, 8'h66, 0, 1, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R6, R8
    mk(18'h05555, 8'h90, 0, 0, 1), mk(18'h3FFFF, 8'hF0, 0, 0, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),
    mk(18'h05555, 8'h90, 0, 0, 1), mk(18'h05555, 8'hAA, 0, 0, 1),
    mk(18'h02AAA, 8'h55, 0, 0, 1), mk(18'h05555, 8'hF0, 0, 0, 0),
    mk(18'h05555, 8'hAA, 0, 0, 0), mk(18'h02AAA, 8'h55, 0, 0, 0),      // R4 bad sixth
    mk(18'h05555, 8'h80, 0, 0, 0), mk(18'h05555, 8'hAA, 0, 0, 0),
    mk(18'h02AAA, 8'h55, 0, 0, 0), mk(18'h05555, 8'h20, 0, 0, 0)
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] reqCode();
    return progReq ? 3'd1 : chipEraseReq ? 3'd2 : sectEraseReq ? 3'd3 :
           lockReq ? 3'd4 : 3'd0;
  endfunction

  task automatic doWrite(input logic [17:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; busy = b;
    @(negedge clk);
    wrEn = 1'b0; busy = 1'b0;
  endtask

  task automatic doRead(input logic [17:0] a, input logic expHit,
                        input logic [7:0] expData, input string req);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdHit === expHit, req, rdHit, expHit);
    check(rdData === expData, req, rdData, expData);
  endtask

  task automatic unlock();
    doWrite(18'h05555, 8'hAA, 0);
    doWrite(18'h02AAA, 8'h55, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    check(reqCode() == 0 && !idMode && !rdHit, "R12 reset outputs", reqCode(), 0);
    check(reqAddr == 0 && reqData == 0 && rdData == 0, "R12 reset latches", reqAddr, 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [17:0] a; logic [7:0] d; logic b; logic [2:0] r; logic i;
      {a, d, b, r, i} = VEC[k];
      doWrite(a, d, b);
      if (r != 0) begin lastAddr = a; lastData = d; end
      check(reqCode() == r, $sformatf("R11 request code vec %0d", k), reqCode(), r);
      check(idMode == i, $sformatf("R8 idMode vec %0d", k), idMode, i);
      check(reqAddr == lastAddr && reqData == lastData,
            $sformatf("R11 latched addr/data vec %0d", k), {reqAddr, reqData},
            {lastAddr, lastData});
    end

    // R11: request is one clock wide
    unlock();
    doWrite(18'h05555, 8'hA0, 0);
    doWrite(18'h0ABCD, 8'h3C, 0);
    check(progReq === 1'b1, "R2 program pulse", progReq, 1);
    @(negedge clk);
    check(reqCode() == 0, "R11 pulse width", reqCode(), 0);

    // R12: reset clears lockout and mode
    unlock();
    doWrite(18'h05555, 8'h90, 0);
    rstN = 1'b0;
    @(negedge clk);
    check(!idMode && reqAddr == 0 && reqData == 0, "R12 reset mid-run", idMode, 0);
    rstN = 1'b1;
    doRead(18'h00000, 0, 8'h00, "R7 read outside id mode");

    // R7: identification reads
    unlock();
    doWrite(18'h05555, 8'h90, 0);
    check(idMode === 1'b1, "R6 enter id", idMode, 1);
    doRead(18'h00000, 1, 8'hDA, "R7 maker code");
    doRead(18'h00001, 1, 8'h0B, "R7 device code");
    doRead(18'h00002, 1, 8'h00, "R7 unlocked state");
    doRead(18'h00007, 0, 8'h00, "R7 other address");
    doRead(18'h20000, 0, 8'h00, "R7 upper address bits");

    // R5: lockout reflected at address 2
    unlock();
    doWrite(18'h05555, 8'h80, 0);
    unlock();
    doWrite(18'h05555, 8'h40, 0);
    check(lockReq === 1'b1, "R5 lock request", lockReq, 1);
    doRead(18'h00002, 1, 8'h01, "R5 locked state");

    doWrite(18'h00042, 8'hF0, 0);
    check(idMode === 1'b0, "R8 single-write exit", idMode, 0);
    doRead(18'h00000, 0, 8'h00, "R7 read after exit");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule